// File: doc/BRIEF.md
# Watchdog timer with debug masking

This block is a watchdog timer with a small word-addressed register port. Software programs a 16-bit starting count, a reload value and a control word. While the run bit is set, a prescaler divides the system clock by 16, 32, 64 or 128 and each divided tick takes one from the counter. A tick that finds the counter at zero is an expiry. On an expiry the counter takes the reload value, a one-cycle reset request may be raised, and an interrupt level may be raised and held until software clears it. Software services the watchdog by writing the count register before the count runs out.

A debug-halt input reports that the processor core is stopped under a debugger. When the debug-mask control bit is set and that input is high, both outputs are held low and any expiry in that time is dropped. This keeps a halted core from being reset by its own watchdog.

Register offsets (byte addresses on `bus_addr`): 0x0 control, 0x4 reload, 0x8 count, 0xC interrupt clear. Control bits: 0 reset enable, 2 interrupt enable, 4:3 division select, 5 run, 16 debug mask.

Top module: `wdg_timer`

## Requirements
- R1: After reset the control register reads 0x0000_0001 (only the reset enable set), the reload and count registers read 0x0000_FFFF, and both outputs are low.
- R2: Control field 4:3 selects a tick every 16 (00), 32 (01), 64 (10) or 128 (11) clocks. Any write to control or count restarts the prescaler from zero.
- R3: The counter drops by one on each tick only while control bit 5 is set. When the bit is clear it holds its value.
- R4: A tick that finds the counter at zero reloads it from the reload register and makes one expiry. If N is in the count register when the run bit is set, the first reset request appears (N+1)*D+1 clocks after that write, where D is the division ratio. Each later one follows (R+1)*D clocks after the one before, where R is the reload value.
- R5: An expiry with control bit 0 set gives a reset request exactly one clock long. With bit 0 clear it gives none.
- R6: An expiry with control bit 2 set raises the interrupt level, in the same cycle as the reset request. The level holds until a write to 0xC with data bit 0 at 1. A write with bit 0 at 0 leaves it high.
- R7: A write to count loads the counter at once. If it falls on the same edge as an expiring tick, the write wins and no expiry happens.
- R8: While control bit 16 is set and the debug-halt input is high, the interrupt and the reset request are low and expiries are discarded. When bit 16 is clear the debug-halt input has no effect.
- R9: If an interrupt-clear write and a new interrupt set fall on the same edge, the interrupt stays high.
- R10: Bits that are not implemented read as zero. Writing all ones to control reads back 0x0001_003D, and to reload reads back 0x0000_FFFF. The clear register reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, zero when not selected) |
| dbg_halt | input | 1 | Core halted in debug |
| irq_o | output | 1 | Interrupt level |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
Two pairs of functions can meet in one clock. A service write to count can land on the exact edge where a tick finds the counter at zero. An interrupt-clear write can land on the edge where a second expiry sets the interrupt again. The bench places each write by cycle arithmetic from the enabling write. It then judges the first case by the new expiry time, (M+1)*D+1 clocks after the service write. It judges the second by the interrupt still being high after the clear.

// File: rtl/wdg_pkg.sv
// Package: shared register offsets, control bit positions and control type
// for the watchdog timer. Assumes byte addressing with word-aligned registers.
package wdg_pkg;
    localparam int OFF_CTRL   = 'h0;
    localparam int OFF_RELOAD = 'h4;
    localparam int OFF_COUNT  = 'h8;
    localparam int OFF_ICLR   = 'hC;

    localparam int CB_RSTEN   = 0;
    localparam int CB_IRQEN   = 2;
    localparam int CB_DIV_LO  = 3;
    localparam int CB_RUN     = 5;
    localparam int CB_DBGMASK = 16;
    localparam int DIV_SEL_W  = 2;

    typedef struct packed {
        logic                 dbg_mask;
        logic                 run;
        logic [DIV_SEL_W-1:0] div_sel;
        logic                 irq_en;
        logic                 rst_en;
    } wdg_ctrl_t;
endpackage

// File: rtl/wdg_regs.sv
// Register file: holds control and reload, decodes writes to count and to
// interrupt clear, and drives the read mux. Assumes DATA_W > CB_DBGMASK and
// DATA_W >= CNT_W.
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt_val,
    output wdg_ctrl_t         ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic              ctrl_wr,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  cnt_wdata,
    output logic              irq_clr,
    output logic [DATA_W-1:0] rdata
);
    logic hit_ctrl, hit_reload, hit_count, hit_iclr;
    logic unused_wdata_bits;

    // Address decode for each register.
    assign hit_ctrl   = sel && (addr == ADDR_W'(OFF_CTRL));
    assign hit_reload = sel && (addr == ADDR_W'(OFF_RELOAD));
    assign hit_count  = sel && (addr == ADDR_W'(OFF_COUNT));
    assign hit_iclr   = sel && (addr == ADDR_W'(OFF_ICLR));

    assign ctrl_wr    = hit_ctrl && wr;
    assign cnt_wr     = hit_count && wr;
    assign cnt_wdata  = wdata[CNT_W-1:0];
    assign irq_clr    = hit_iclr && wr && wdata[0];
    assign unused_wdata_bits = ^wdata;

    // Control and reload storage with their reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl   <= '{dbg_mask: 1'b0, run: 1'b0, div_sel: '0, irq_en: 1'b0, rst_en: 1'b1};
            reload <= '1;
        end else begin
            if (ctrl_wr) begin
                ctrl.rst_en   <= wdata[CB_RSTEN];
                ctrl.irq_en   <= wdata[CB_IRQEN];
                ctrl.div_sel  <= wdata[CB_DIV_LO +: DIV_SEL_W];
                ctrl.run      <= wdata[CB_RUN];
                ctrl.dbg_mask <= wdata[CB_DBGMASK];
            end
            if (hit_reload && wr) begin
                reload <= wdata[CNT_W-1:0];
            end
        end
    end

    // Read mux; unimplemented bits and the clear register read as zero.
    always_comb begin
        rdata = '0;
        if (hit_ctrl) begin
            rdata[CB_RSTEN]                   = ctrl.rst_en;
            rdata[CB_IRQEN]                   = ctrl.irq_en;
            rdata[CB_DIV_LO +: DIV_SEL_W]     = ctrl.div_sel;
            rdata[CB_RUN]                     = ctrl.run;
            rdata[CB_DBGMASK]                 = ctrl.dbg_mask;
        end else if (hit_reload) begin
            rdata[CNT_W-1:0] = reload;
        end else if (hit_count) begin
            rdata[CNT_W-1:0] = cnt_val;
        end
    end

    // R10: a write to reload is visible on the next cycle
    assert_reload_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_reload && wr) |=> reload == $past(wdata[CNT_W-1:0]));
endmodule

// File: rtl/wdg_prescaler.sv
// Prescaler: one-cycle tick every 2**(BASE_LOG2+div_sel) clocks while run is
// set. A restart (register write) clears the phase and suppresses the tick.
module wdg_prescaler #(
    parameter int BASE_LOG2 = 4,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int PW = BASE_LOG2 + (1 << SEL_W) - 1;

    logic [PW-1:0] phase;
    logic [PW:0]   span;
    logic [PW-1:0] limit;

    // Terminal phase value for the selected ratio.
    always_comb begin
        span  = (PW+1)'(1) << (BASE_LOG2 + int'(div_sel));
        limit = PW'(span - (PW+1)'(1));
    end

    assign tick = run && !restart && (phase == limit);

    // Phase counter: cleared when stopped or restarted, wraps at the tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run || tick) begin
            phase <= '0;
        end else begin
            phase <= phase + PW'(1);
        end
    end

    // R2: ticks are never back to back (ratio is at least 2)
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // R3: a stopped prescaler gives no tick on the following cycle
    assert_no_tick_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> phase == '0);
endmodule

// File: rtl/wdg_counter.sv
// Down counter: loads on a register write, steps on each tick, reloads on a
// tick at zero and flags that as a registered one-cycle expiry.
module wdg_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic at_zero;
    assign at_zero = (count == '0);

    // Count update; a write takes priority over a tick in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '1;
            expire <= 1'b0;
        end else begin
            expire <= tick && at_zero && !load;
            if (load) begin
                count <= load_val;
            end else if (tick) begin
                count <= at_zero ? reload_val : count - CNT_W'(1);
            end
        end
    end

    // R3: without tick or write the count holds
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> count == $past(count));
    // R4: a tick at zero reloads and flags one expiry
    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && at_zero) |=> (expire && count == $past(reload_val)));
    // R7: a write wins over an expiring tick
    assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!expire && count == $past(load_val)));
endmodule

// File: rtl/wdg_alarm.sv
// Alarm outputs: one-cycle reset request and held interrupt level, both
// gated by the debug mask while the debug-halt input is high.
module wdg_alarm (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic rst_en,
    input  logic irq_en,
    input  logic dbg_mask,
    input  logic dbg_halt,
    input  logic irq_clr,
    output logic irq_o,
    output logic rst_req_o
);
    logic masked;
    logic rst_q;
    logic pend;

    assign masked = dbg_mask && dbg_halt;

    // Reset pulse and interrupt pending; a new set beats a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            rst_q <= expire && rst_en && !masked;
            if (expire && irq_en && !masked) begin
                pend <= 1'b1;
            end else if (irq_clr) begin
                pend <= 1'b0;
            end
        end
    end

    assign irq_o     = pend && !masked;
    assign rst_req_o = rst_q && !masked;

    // R5: the reset request lasts one cycle
    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |=> !rst_q);
    // R6: pending holds unless cleared
    assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !irq_clr) |=> pend);
    // R6: pending only rises when interrupts were enabled
    assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(irq_en));
    // R8: an expiry while masked leaves no reset request
    assert_masked_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (masked && expire) |=> !rst_q);
endmodule

// File: rtl/wdg_timer.sv
// Watchdog timer top: register port, prescaler, down counter and alarm
// outputs with debug masking. Assumes a single clock and synchronous reset.
module wdg_timer
    import wdg_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int CNT_W     = 16,
    parameter int BASE_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dbg_halt,
    output logic              irq_o,
    output logic              rst_req_o
);
    wdg_ctrl_t        ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cnt_wdata;
    logic             ctrl_wr, cnt_wr, irq_clr, tick, expire;

    wdg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .cnt_val(count), .ctrl(ctrl), .reload(reload),
        .ctrl_wr(ctrl_wr), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .irq_clr(irq_clr), .rdata(bus_rdata)
    );

    wdg_prescaler #(.BASE_LOG2(BASE_LOG2), .SEL_W(DIV_SEL_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .restart(ctrl_wr || cnt_wr),
        .div_sel(ctrl.div_sel), .tick(tick)
    );

    wdg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_wr),
        .load_val(cnt_wdata), .reload_val(reload), .count(count), .expire(expire)
    );

    wdg_alarm u_alarm (
        .clk(clk), .rst_n(rst_n), .expire(expire), .rst_en(ctrl.rst_en),
        .irq_en(ctrl.irq_en), .dbg_mask(ctrl.dbg_mask), .dbg_halt(dbg_halt),
        .irq_clr(irq_clr), .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    // R1: outputs stay low in the first cycle after reset
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_o && !rst_req_o));
endmodule

// File: tb/wdg_timer_bench.sv
// Bench: sweeps every division ratio against several start counts, then the
// reload period, hold, service race, clear race, masking and readback.
module wdg_timer_bench;
    localparam int CLK_P = 10;
    localparam logic [3:0] A_CTRL = 4'h0, A_RLD = 4'h4, A_CNT = 4'h8, A_CLR = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, dbg_halt = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, rst_req_o;
    int checks = 0, errors = 0;

    wdg_timer u_wdg_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dbg_halt(dbg_halt), .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [31:0] ctl(input bit run, input bit irq, input bit rst,
                                        input int dsel, input bit mask);
        return (32'(mask) << 16) | (32'(run) << 5) | (32'(dsel & 3) << 3) |
               (32'(irq) << 2) | 32'(rst);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_rst(input int limit, output int k, output logic irq_at);
        k = 0; irq_at = 1'b0;
        for (int i = 1; i <= limit; i++) begin
            step(1);
            if (rst_req_o) begin k = i; irq_at = irq_o; break; end
        end
    endtask

    task automatic arm(input int cnt, input int rld);
        wr(A_CTRL, 32'h1);
        wr(A_RLD, 32'(rld));
        wr(A_CNT, 32'(cnt));
        wr(A_CLR, 32'h1);
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int k, dv;
        logic ia;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1: reset state
        rd(A_CTRL, d); check("R1 ctrl", d, 32'h1);
        rd(A_RLD, d);  check("R1 reload", d, 32'hFFFF);
        rd(A_CNT, d);  check("R1 count", d, 32'hFFFF);
        check("R1 outputs", {30'b0, irq_o, rst_req_o}, 32'h0);

        // R2 R4 R5 R6: every ratio against several start counts
        for (int s = 0; s < 4; s++) begin
            for (int n = 0; n < 3; n++) begin
                dv = 16 << s;
                arm(n, 16'hFFFF);
                wr(A_CTRL, ctl(1, 1, 1, s, 0));
                wait_rst((n + 1) * dv + 10, k, ia);
                check("R2 R4 first expiry time", 32'(k), 32'((n + 1) * dv + 1));
                check("R6 irq with reset", 32'(ia), 32'h1);
                step(1);
                check("R5 single cycle pulse", 32'(rst_req_o), 32'h0);
                wr(A_CTRL, 32'h1);
                wr(A_CLR, 32'h0);
                check("R6 zero clear ignored", 32'(irq_o), 32'h1);
                wr(A_CLR, 32'h1);
                check("R6 clear", 32'(irq_o), 32'h0);
            end
        end

        // R4: reload period
        arm(0, 2);
        wr(A_CTRL, ctl(1, 1, 1, 1, 0));
        wait_rst(100, k, ia);
        check("R4 first", 32'(k), 32'd33);
        wait_rst(200, k, ia);
        check("R4 reload period", 32'(k), 32'd96);

        // R5: reset enable clear gives interrupt only
        arm(0, 16'hFFFF);
        wr(A_CTRL, ctl(1, 1, 0, 0, 0));
        wait_rst(40, k, ia);
        check("R5 no reset when disabled", 32'(k), 32'h0);
        check("R6 irq without reset", 32'(irq_o), 32'h1);

        // R3: hold while stopped, step while running
        arm(5, 16'hFFFF);
        step(300);
        rd(A_CNT, d); check("R3 hold stopped", d, 32'd5);
        wr(A_CTRL, ctl(1, 0, 1, 0, 0));
        step(32);
        rd(A_CNT, d); check("R3 two ticks", d, 32'd3);
        wr(A_CTRL, 32'h1);
        step(100);
        rd(A_CNT, d); check("R3 hold after stop", d, 32'd3);

        // R7: service write on the expiring edge
        arm(1, 16'hFFFF);
        wr(A_CTRL, ctl(1, 1, 1, 0, 0));
        step(31);
        wr(A_CNT, 32'd2);
        wait_rst(80, k, ia);
        check("R7 service wins race", 32'(k), 32'd49);

        // R9: clear on the edge of a new set
        arm(0, 1);
        wr(A_CTRL, ctl(1, 1, 1, 0, 0));
        step(48);
        wr(A_CLR, 32'h1);
        check("R9 set beats clear", 32'(irq_o), 32'h1);
        wr(A_CLR, 32'h1);
        check("R9 plain clear", 32'(irq_o), 32'h0);

        // R8: masked and halted drops expiries
        arm(0, 16'hFFFF);
        dbg_halt = 1'b1;
        wr(A_CTRL, ctl(1, 1, 1, 0, 1));
        wait_rst(60, k, ia);
        check("R8 no reset while masked", 32'(k), 32'h0);
        check("R8 no irq while masked", 32'(irq_o), 32'h0);
        dbg_halt = 1'b0;
        step(1);
        check("R8 expiry discarded", 32'(irq_o), 32'h0);

        // R8: mask set, halt low behaves normally; halt gates the level
        arm(0, 16'hFFFF);
        wr(A_CTRL, ctl(1, 1, 1, 0, 1));
        wait_rst(40, k, ia);
        check("R8 halt low no effect", 32'(k), 32'd17);
        dbg_halt = 1'b1;
        #1 check("R8 halt hides irq", 32'(irq_o), 32'h0);
        dbg_halt = 1'b0;
        #1 check("R8 irq returns", 32'(irq_o), 32'h1);

        // R8: mask clear, halt high ignored
        arm(0, 16'hFFFF);
        dbg_halt = 1'b1;
        wr(A_CTRL, ctl(1, 1, 1, 0, 0));
        wait_rst(40, k, ia);
        check("R8 halt ignored unmasked", 32'(k), 32'd17);
        dbg_halt = 1'b0;

        // R10: readback of implemented bits
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, d); check("R10 ctrl bits", d, 32'h0001_003D);
        wr(A_CTRL, 32'h1);
        wr(A_RLD, 32'hFFFF_FFFF);
        rd(A_RLD, d); check("R10 reload bits", d, 32'h0000_FFFF);
        rd(A_CLR, d); check("R10 clear reads zero", d, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule